// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block converts pending interrupt sources into a complete processor interrupt entry. It watches three sources: an active-low maskable request, an active-low non-maskable request, and a software-interrupt strobe from the instruction decoder. When the core signals an instruction boundary and a source is eligible, the sequencer snapshots the core's registers. It writes them as seven bytes onto a memory stack addressed by its own 16-bit stack pointer. It then fetches a two-byte handler address from a fixed high-memory vector and presents the new program counter, with the mask bit now set, back to the core.

The same engine also performs the return from an interrupt. It reads the seven bytes back in the opposite order and hands the restored context to the core. All memory traffic goes through one synchronous byte port: read data appears the cycle after the address. The instruction datapath and the ALU live elsewhere. The sequencer only moves state between the core and memory.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset the block is idle (`busy`=0), writes nothing, shows no `ctx_valid` or `vec_loaded` pulse, and `sp_out` equals the `SP_RESET` parameter (default 16'h00FF).
- R2: A falling edge on `nmi_n` is latched until that request is accepted, even if the line returns high first; holding `nmi_n` low after acceptance does not cause a second entry.
- R3: The maskable request is level sensitive (`irq_n`=0) and is accepted only when bit 4 of `cc_in` (the mask bit) is 0; while that bit is 1 the request has no effect.
- R4: Requests are sampled only on a cycle with `boundary`=1 while idle. The order is non-maskable first, then software interrupt, then maskable. A boundary that arrives while `busy`=1 is ignored.
- R5: An entry issues exactly seven write cycles. The first goes to the current stack pointer and each following one goes to the address one lower. The bytes are written in this order: PC[7:0], PC[15:8], X[7:0], X[15:8], A, B, CC, where CC is the unmodified `cc_in`.
- R6: The handler address is read high byte first from the even vector address, then low byte from the next address. The vector addresses are 16'hFFFC for non-maskable, 16'hFFFA for software and 16'hFFF8 for maskable.
- R7: An entry completes with a one-cycle `vec_loaded` pulse, together with `ctx_valid`. In that cycle `pc_out` holds the vector, `cc_out` holds the stacked CC with bit 4 forced to 1, and `x_out`, `a_out` and `b_out` hold the snapshot values.
- R8: A boundary with `rti_req`=1 and no eligible interrupt performs seven reads. Each read goes to the stack pointer plus one, and the pointer is incremented each time. The sequence ends with a `ctx_valid` pulse, without `vec_loaded`, carrying exactly the previously stacked PC, X, A, B and CC.
- R9: `sp_out` is 7 lower after an entry and 7 higher after a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| swi_req | input | 1 | Software interrupt from decoder, sampled at boundary |
| rti_req | input | 1 | Return-from-interrupt from decoder, sampled at boundary |
| boundary | input | 1 | Instruction boundary marker from the core |
| pc_in | input | 16 | Current program counter |
| x_in | input | 16 | Current index register |
| a_in | input | 8 | Current accumulator A |
| b_in | input | 8 | Current accumulator B |
| cc_in | input | 8 | Current condition codes, bit 4 is the mask |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| busy | output | 1 | Sequence in progress |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter for the core, valid with ctx_valid |
| x_out | output | 16 | Index register for the core |
| a_out | output | 8 | Accumulator A for the core |
| b_out | output | 8 | Accumulator B for the core |
| cc_out | output | 8 | Condition codes for the core |
| ctx_valid | output | 1 | One-cycle pulse: outputs above are to be loaded |
| vec_loaded | output | 1 | One-cycle pulse: an entry fetched its vector |

## Verification
The hardest situation to reach is a boundary where all three sources are eligible at once. Reaching it also requires that the non-maskable edge has already been latched and that the core's mask bit is clear. The stimulus drops `nmi_n` one cycle before the boundary and holds `irq_n` low. It then raises `swi_req` on the boundary itself. After each handler it forces the mask bit during the return so that the still-asserted maskable line cannot pre-empt the return. The remaining sources are then drained one at a time. A scoreboard predicts every stack write and every restored context, so an out-of-order push or a wrong winner shows up as a data mismatch.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 8;
    localparam int NUM_STACKED = 7;
    localparam int CNT_W       = $clog2(NUM_STACKED);

    localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFF8;
    localparam logic [ADDR_W-1:0] VEC_SWI = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC_H,
        ST_VEC_L,
        ST_VEC_D,
        ST_POP,
        ST_POP_END
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_SWI,
        SRC_IRQ
    } src_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] x;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] cc;
    } ctx_t;

    function automatic logic [ADDR_W-1:0] vec_base(src_e s);
        case (s)
            SRC_NMI: return VEC_NMI;
            SRC_SWI: return VEC_SWI;
            default: return VEC_IRQ;
        endcase
    endfunction

    // Stack slot numbering: 0 PCL, 1 PCH, 2 XL, 3 XH, 4 A, 5 B, 6 CC
    function automatic logic [DATA_W-1:0] ctx_byte(ctx_t c, logic [CNT_W-1:0] idx);
        case (idx)
            3'd0:    return c.pc[7:0];
            3'd1:    return c.pc[15:8];
            3'd2:    return c.x[7:0];
            3'd3:    return c.x[15:8];
            3'd4:    return c.a;
            3'd5:    return c.b;
            default: return c.cc;
        endcase
    endfunction

    function automatic ctx_t ctx_put(ctx_t c, logic [CNT_W-1:0] idx, logic [DATA_W-1:0] v);
        ctx_t r;
        r = c;
        case (idx)
            3'd0:    r.pc[7:0]  = v;
            3'd1:    r.pc[15:8] = v;
            3'd2:    r.x[7:0]   = v;
            3'd3:    r.x[15:8]  = v;
            3'd4:    r.a        = v;
            3'd5:    r.b        = v;
            default: r.cc       = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic clr,
    output logic pend
);
    logic nmi_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_d <= 1'b1;
            pend  <= 1'b0;
        end else begin
            nmi_d <= nmi_n;
            pend  <= (pend & ~clr) | (nmi_d & ~nmi_n);
        end
    end

    // R2
    nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
(
    input  logic nmi_pend,
    input  logic swi_req,
    input  logic irq_live,
    output src_e src
);
    always_comb begin
        if (nmi_pend)      src = SRC_NMI;
        else if (swi_req)  src = SRC_SWI;
        else if (irq_live) src = SRC_IRQ;
        else               src = SRC_NONE;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter logic [15:0] SP_RESET = 16'h00FF,
    parameter int          I_BIT    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq_n,
    input  logic        nmi_n,
    input  logic        swi_req,
    input  logic        rti_req,
    input  logic        boundary,
    input  logic [15:0] pc_in,
    input  logic [15:0] x_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  b_in,
    input  logic [7:0]  cc_in,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic [15:0] sp_out,
    output logic [15:0] pc_out,
    output logic [15:0] x_out,
    output logic [7:0]  a_out,
    output logic [7:0]  b_out,
    output logic [7:0]  cc_out,
    output logic        ctx_valid,
    output logic        vec_loaded
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_STACKED - 1);

    seq_state_e         state;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  sp;
    logic [ADDR_W-1:0]  vec_q;
    logic [DATA_W-1:0]  hi_q;
    ctx_t               snap;
    ctx_t               res;
    ctx_t               fin;
    logic               nmi_pend;
    logic               nmi_clr;
    logic               take_int;
    src_e               src;

    nmi_edge_latch u_nmi (
        .clk   (clk),
        .rst   (rst),
        .nmi_n (nmi_n),
        .clr   (nmi_clr),
        .pend  (nmi_pend)
    );

    irq_arbiter u_arb (
        .nmi_pend (nmi_pend),
        .swi_req  (swi_req),
        .irq_live (~irq_n & ~cc_in[I_BIT]),
        .src      (src)
    );

    assign take_int = (state == ST_IDLE) && boundary && (src != SRC_NONE);
    assign nmi_clr  = take_int && (src == SRC_NMI);

    always_comb begin
        fin          = snap;
        fin.pc       = {hi_q, mem_rdata};
        fin.cc[I_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            sp         <= SP_RESET;
            vec_q      <= '0;
            hi_q       <= '0;
            snap       <= '0;
            res        <= '0;
            ctx_valid  <= 1'b0;
            vec_loaded <= 1'b0;
        end else begin
            ctx_valid  <= 1'b0;
            vec_loaded <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (take_int) begin
                        snap  <= '{pc: pc_in, x: x_in, a: a_in, b: b_in, cc: cc_in};
                        vec_q <= vec_base(src);
                        state <= ST_PUSH;
                    end else if (boundary && rti_req) begin
                        state <= ST_POP;
                    end
                end
                ST_PUSH: begin
                    sp <= sp - 1'b1;
                    if (cnt == LAST) state <= ST_VEC_H;
                    else             cnt   <= cnt + 1'b1;
                end
                ST_VEC_H: state <= ST_VEC_L;
                ST_VEC_L: begin
                    hi_q  <= mem_rdata;
                    state <= ST_VEC_D;
                end
                ST_VEC_D: begin
                    res        <= fin;
                    ctx_valid  <= 1'b1;
                    vec_loaded <= 1'b1;
                    state      <= ST_IDLE;
                end
                ST_POP: begin
                    sp <= sp + 1'b1;
                    if (cnt != '0)
                        snap <= ctx_put(snap, CNT_W'(LAST - cnt + 1'b1), mem_rdata);
                    if (cnt == LAST) state <= ST_POP_END;
                    else             cnt   <= cnt + 1'b1;
                end
                ST_POP_END: begin
                    res       <= ctx_put(snap, '0, mem_rdata);
                    ctx_valid <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = (state == ST_PUSH);
        mem_wdata = mem_we ? ctx_byte(snap, cnt) : '0;
        case (state)
            ST_PUSH:  mem_addr = sp;
            ST_VEC_H: mem_addr = vec_q;
            ST_VEC_L: mem_addr = vec_q + 1'b1;
            ST_POP:   mem_addr = sp + 1'b1;
            default:  mem_addr = sp;
        endcase
    end

    assign busy   = (state != ST_IDLE);
    assign sp_out = sp;
    assign pc_out = res.pc;
    assign x_out  = res.x;
    assign a_out  = res.a;
    assign b_out  = res.b;
    assign cc_out = res.cc;

    // R5
    push_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

    // R8
    pop_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POP && cnt != '0) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R4
    idle_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we);

    // R7
    vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vec_loaded |=> !vec_loaded);

    // R7
    vec_mask_chk: assert property (@(posedge clk) disable iff (rst)
        vec_loaded |-> (cc_out[I_BIT] && ctx_valid && !busy));

endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_n = 1'b1, nmi_n = 1'b1, swi_req = 1'b0, rti_req = 1'b0, boundary = 1'b0;
    logic [15:0] pc_in = '0, x_in = '0;
    logic [7:0]  a_in = '0, b_in = '0, cc_in = '0;
    logic [15:0] mem_addr, sp_out, pc_out, x_out;
    logic [7:0]  mem_wdata, mem_rdata, a_out, b_out, cc_out;
    logic        mem_we, busy, ctx_valid, vec_loaded;

    always #2.5 clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst(rst), .irq_n(irq_n), .nmi_n(nmi_n), .swi_req(swi_req),
        .rti_req(rti_req), .boundary(boundary), .pc_in(pc_in), .x_in(x_in),
        .a_in(a_in), .b_in(b_in), .cc_in(cc_in), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .busy(busy), .sp_out(sp_out), .pc_out(pc_out), .x_out(x_out),
        .a_out(a_out), .b_out(b_out), .cc_out(cc_out), .ctx_valid(ctx_valid),
        .vec_loaded(vec_loaded)
    );

    logic [7:0] mem [0:511];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[8:0]];
    end

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
    } wr_t;

    typedef struct {
        logic [15:0] pc;
        logic [15:0] x;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [7:0]  cc;
        logic        vec;
        logic [15:0] sp;
        string       tag;
    } res_t;

    wr_t  wq[$];
    res_t rq[$];
    res_t saved[$];
    int   checks = 0;
    int   fails = 0;
    logic [15:0] m_sp = 16'h00FF;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (!rst && mem_we) begin
            if (wq.size() == 0) begin
                check(1'b0, "R4", "unexpected stack write addr", {16'h0, mem_addr}, 32'h0);
            end else begin
                wr_t w;
                w = wq.pop_front();
                check(mem_addr == w.addr, "R5", "push address", {16'h0, mem_addr}, {16'h0, w.addr});
                check(mem_wdata == w.data, "R5", "push data", {24'h0, mem_wdata}, {24'h0, w.data});
            end
        end
        if (!rst && ctx_valid) begin
            if (rq.size() == 0) begin
                check(1'b0, "R4", "unexpected ctx_valid pc", {16'h0, pc_out}, 32'h0);
            end else begin
                res_t r;
                r = rq.pop_front();
                check(pc_out == r.pc, r.vec ? "R6" : "R8", {r.tag, " pc"}, {16'h0, pc_out}, {16'h0, r.pc});
                check(cc_out == r.cc, r.vec ? "R7" : "R8", {r.tag, " cc"}, {24'h0, cc_out}, {24'h0, r.cc});
                check({x_out, a_out, b_out} == {r.x, r.a, r.b}, r.vec ? "R7" : "R8", {r.tag, " x/a/b"},
                      {x_out, a_out, b_out}, {r.x, r.a, r.b});
                check(vec_loaded == r.vec, r.vec ? "R7" : "R8", {r.tag, " vec_loaded"},
                      {31'h0, vec_loaded}, {31'h0, r.vec});
                check(sp_out == r.sp, "R9", {r.tag, " sp_out"}, {16'h0, sp_out}, {16'h0, r.sp});
            end
        end
        if (!rst && vec_loaded && !ctx_valid)
            check(1'b0, "R7", "vec_loaded without ctx_valid", 32'h1, 32'h0);
    end

    task automatic expect_entry(logic [15:0] vec, string tag);
        res_t r;
        logic [7:0] b [7];
        b[0] = pc_in[7:0]; b[1] = pc_in[15:8]; b[2] = x_in[7:0]; b[3] = x_in[15:8];
        b[4] = a_in; b[5] = b_in; b[6] = cc_in;
        for (int i = 0; i < 7; i++) wq.push_back('{addr: m_sp - 16'(i), data: b[i]});
        r = '{pc: pc_in, x: x_in, a: a_in, b: b_in, cc: cc_in, vec: 1'b0, sp: m_sp, tag: tag};
        saved.push_back(r);
        m_sp = m_sp - 16'd7;
        r = '{pc: vec, x: x_in, a: a_in, b: b_in, cc: cc_in | 8'h10, vec: 1'b1, sp: m_sp, tag: tag};
        rq.push_back(r);
    endtask

    task automatic expect_rti(string tag);
        res_t r;
        r = saved.pop_back();
        m_sp = m_sp + 16'd7;
        r.sp = m_sp;
        r.vec = 1'b0;
        r.tag = tag;
        rq.push_back(r);
    endtask

    task automatic pulse_boundary(bit swi, bit rti);
        @(negedge clk);
        boundary = 1'b1; swi_req = swi; rti_req = rti;
        @(negedge clk);
        boundary = 1'b0; swi_req = 1'b0; rti_req = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_regs(logic [15:0] pc, logic [15:0] x, logic [7:0] a, logic [7:0] b, logic [7:0] cc);
        pc_in = pc; x_in = x; a_in = a; b_in = b; cc_in = cc;
    endtask

    task automatic do_rti(string tag);
        logic [7:0] keep;
        keep = cc_in;
        cc_in = 8'h10;
        expect_rti(tag);
        pulse_boundary(1'b0, 1'b1);
        wait_idle();
        cc_in = keep;
    endtask

    task automatic check_quiet(string req, string what);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, req, what, {31'h0, busy}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        mem[9'h1F8] = 8'h12; mem[9'h1F9] = 8'h34;
        mem[9'h1FA] = 8'h56; mem[9'h1FB] = 8'h78;
        mem[9'h1FC] = 8'h9A; mem[9'h1FD] = 8'hBC;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", {31'h0, busy}, 32'h0);
        check(mem_we == 1'b0, "R1", "mem_we after reset", {31'h0, mem_we}, 32'h0);
        check({ctx_valid, vec_loaded} == 2'b00, "R1", "pulses after reset", {30'h0, ctx_valid, vec_loaded}, 32'h0);
        check(sp_out == 16'h00FF, "R1", "sp after reset", {16'h0, sp_out}, 32'h00FF);

        // R3: unmasked level request, then return (R8)
        set_regs(16'h2000, 16'hAB01, 8'h11, 8'h22, 8'h00);
        irq_n = 1'b0;
        expect_entry(16'h1234, "R3 irq");
        pulse_boundary(1'b0, 1'b0);
        irq_n = 1'b1;
        wait_idle();
        do_rti("R8 rti after irq");

        // R3: masked request has no effect
        set_regs(16'h2100, 16'h0000, 8'h01, 8'h02, 8'h10);
        irq_n = 1'b0;
        pulse_boundary(1'b0, 1'b0);
        check_quiet("R3", "masked irq started entry");
        irq_n = 1'b1;

        // R2: short nmi pulse is latched, serviced with mask set
        set_regs(16'h3456, 16'h7788, 8'hA5, 8'h5A, 8'hD1);
        @(negedge clk) nmi_n = 1'b0;
        @(negedge clk) nmi_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_entry(16'h9ABC, "R2 latched nmi");
        pulse_boundary(1'b0, 1'b0);
        wait_idle();
        do_rti("R8 rti after nmi");

        // R2: held-low nmi services once only
        set_regs(16'h4000, 16'h0102, 8'h03, 8'h04, 8'h00);
        @(negedge clk) nmi_n = 1'b0;
        expect_entry(16'h9ABC, "R2 nmi level");
        pulse_boundary(1'b0, 1'b0);
        wait_idle();
        do_rti("R8 rti nmi level");
        pulse_boundary(1'b0, 1'b0);
        check_quiet("R2", "held nmi re-entered");
        nmi_n = 1'b1;

        // R4: all three pending at one boundary
        set_regs(16'h5000, 16'hCAFE, 8'h77, 8'h88, 8'h01);
        irq_n = 1'b0;
        @(negedge clk) nmi_n = 1'b0;
        expect_entry(16'h9ABC, "R4 nmi wins");
        pulse_boundary(1'b1, 1'b0);
        wait_idle();
        do_rti("R8 rti prio1");
        set_regs(16'h5100, 16'hBEEF, 8'h99, 8'hAA, 8'h02);
        expect_entry(16'h5678, "R4 swi over irq");
        pulse_boundary(1'b1, 1'b0);
        wait_idle();
        do_rti("R8 rti prio2");
        set_regs(16'h5200, 16'hF00D, 8'hBB, 8'hCC, 8'h04);
        expect_entry(16'h1234, "R4 irq last");
        pulse_boundary(1'b0, 1'b0);
        irq_n = 1'b1;
        nmi_n = 1'b1;
        wait_idle();
        do_rti("R8 rti prio3");

        // R4: boundary during a sequence is ignored
        set_regs(16'h6000, 16'h1111, 8'h22, 8'h33, 8'h00);
        expect_entry(16'h5678, "R4 busy swi");
        pulse_boundary(1'b1, 1'b0);
        repeat (2) @(negedge clk);
        pulse_boundary(1'b1, 1'b0);
        wait_idle();
        check(busy == 1'b0, "R4", "busy after ignored boundary", {31'h0, busy}, 32'h0);
        do_rti("R8 rti busy");

        check(wq.size() == 0, "R5", "pending expected writes", wq.size(), 32'h0);
        check(rq.size() == 0, "R7", "pending expected results", rq.size(), 32'h0);
        check(sp_out == 16'h00FF, "R9", "sp back at top", {16'h0, sp_out}, 32'h00FF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule